// File: doc/BRIEF.md
# Selectable Rate Triangle Carrier

This block produces the sampled triangular carrier that a single-carrier multilevel PWM modulator compares against its modulation words. All logic runs on one master clock. A prescaler counter divides that clock into a set of step enables whose rates are related by powers of two. A two-bit rate code selects one of these enables. The selected enable advances a modulo address counter through one carrier period of 98 samples. The address reads a triangle table, and the table is computed when the design is elaborated.

Changing the rate code moves the frequency modulation ratio between 20, 40, 80 and 160. Each step up doubles the carrier rate. The new code takes effect only at the boundary between two carrier periods, so no period is ever cut short. The carrier word is a plain continuous output with no valid/ready handshake. It holds each sample until the next step, and a consumer cannot apply back-pressure. A one-clock strobe marks the start of every carrier period.

Top module: `tri_carrier_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `carrier` is 0 and `period_stb` is 0.
- R2: A carrier period consists of exactly `STEPS` (98) samples. The sample index advances by one on each selected step enable and returns from 97 to 0.
- R3: The carrier word for sample index i is `FULL_SCALE*i/PEAK_IDX` for i up to `PEAK_IDX` (48). Above that it is `FULL_SCALE*(STEPS-i)/(STEPS-PEAK_IDX)`. Both use integer division. The highest value in a period is exactly `FULL_SCALE`.
- R4: With active rate code c (0..3), every sample lasts `BASE_DIV >> c` clocks, so one carrier period lasts `STEPS*(BASE_DIV >> c)` clocks. Codes 0, 1, 2 and 3 stand for ratios 20, 40, 80 and 160.
- R5: `period_stb` is high for exactly one clock in each period. That clock is the first clock in which the carrier shows sample 0 of a new period.
- R6: `ratio_sel` is sampled only on the clock edge at which the index wraps from 97 to 0. A change at any other time has no effect on the current period. The first period after reset always uses code 0.
- R7: The prescaler restarts at every period boundary. Because of this, a period that follows a code change has its full nominal length from its first sample onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 2 | Requested rate code, 0 = slowest (ratio 20) to 3 = fastest (ratio 160) |
| carrier | output | 16 | Current triangle carrier sample |
| period_stb | output | 1 | One-clock pulse at the start of each carrier period |

## Verification
The bench builds the block with its default values: `BASE_DIV` 8, `STEPS` 98, `PEAK_IDX` 48 and `FULL_SCALE` 4800. With these, every rate code from divide-by-8 down to divide-by-1 is reached within a few thousand clocks, and the table values divide exactly at both slopes. The rate code is changed at points that fall in the middle of periods, so both the deferral at the wrap and the full length of the period after a change are exercised. A behavioural model tracks the sample index and dwell time, and predicts the carrier word and the strobe on every clock. Separate counts of period length and sample changes are taken at each strobe.

// File: rtl/tri_carrier_pkg.sv
package tri_carrier_pkg;

  // Triangle sample: linear rise to the peak index, linear fall back toward zero.
  function automatic int unsigned tri_point(input int unsigned idx,
                                            input int unsigned steps,
                                            input int unsigned peak,
                                            input int unsigned full);
    if (idx <= peak)
      return (full * idx) / peak;
    else
      return (full * (steps - idx)) / (steps - peak);
  endfunction

endpackage

// File: rtl/tri_prescaler.sv
module tri_prescaler #(
  parameter int BASE_DIV  = 8,
  parameter int NUM_RATES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 restart,
  output logic [NUM_RATES-1:0] rate_en
);
  localparam int PRE_W = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || restart) pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

  // Rate k fires when the low (PRE_W-k) bits are all ones: divide by BASE_DIV>>k.
  for (genvar k = 0; k < NUM_RATES; k++) begin : g_rate
    localparam int LOW = PRE_W - k;
    if (LOW <= 0) begin : g_full
      assign rate_en[k] = 1'b1;
    end else begin : g_div
      assign rate_en[k] = &pre_q[LOW-1:0];
    end
  end

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pre_q == '0)); // R7
endmodule

// File: rtl/tri_rate_sel.sv
module tri_rate_sel #(
  parameter int NUM_RATES = 4,
  parameter int SEL_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [SEL_W-1:0]     sel_in,
  input  logic [NUM_RATES-1:0] rate_en,
  output logic                 step
);
  logic [SEL_W-1:0] active_q;

  always_ff @(posedge clk) begin
    if (rst)       active_q <= '0;
    else if (load) active_q <= sel_in;
  end

  always_comb begin
    step = 1'b0;
    for (int k = 0; k < NUM_RATES; k++)
      if (active_q == SEL_W'(k)) step = rate_en[k];
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(active_q)); // R6
endmodule

// File: rtl/tri_rom.sv
module tri_rom #(
  parameter int STEPS      = 98,
  parameter int PEAK_IDX   = 48,
  parameter int DATA_W     = 16,
  parameter int FULL_SCALE = 4800,
  parameter int ADDR_W     = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  logic [DATA_W-1:0] table_w [STEPS];

  for (genvar g = 0; g < STEPS; g++) begin : g_entry
    assign table_w[g] = DATA_W'(tri_carrier_pkg::tri_point(g, STEPS, PEAK_IDX, FULL_SCALE));
  end

  always_comb begin
    data = '0;
    for (int i = 0; i < STEPS; i++)
      if (addr == ADDR_W'(i)) data = table_w[i];
  end
endmodule

// File: rtl/tri_carrier_gen.sv
module tri_carrier_gen #(
  parameter int BASE_DIV   = 8,
  parameter int STEPS      = 98,
  parameter int PEAK_IDX   = 48,
  parameter int DATA_W     = 16,
  parameter int FULL_SCALE = 4800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        ratio_sel,
  output logic [DATA_W-1:0] carrier,
  output logic              period_stb
);
  localparam int NUM_RATES = 4;
  localparam int SEL_W     = 2;
  localparam int ADDR_W    = $clog2(STEPS);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(STEPS - 1);

  logic [NUM_RATES-1:0] rate_en;
  logic                 step;
  logic                 wrap;
  logic [ADDR_W-1:0]    addr_q;
  logic                 stb_q;

  assign wrap = step && (addr_q == LAST);

  tri_prescaler #(.BASE_DIV(BASE_DIV), .NUM_RATES(NUM_RATES)) u_pre (
    .clk(clk), .rst(rst), .restart(wrap), .rate_en(rate_en));

  tri_rate_sel #(.NUM_RATES(NUM_RATES), .SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst(rst), .load(wrap), .sel_in(ratio_sel),
    .rate_en(rate_en), .step(step));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= wrap;
      if (wrap)      addr_q <= '0;
      else if (step) addr_q <= addr_q + 1'b1;
    end
  end

  tri_rom #(.STEPS(STEPS), .PEAK_IDX(PEAK_IDX), .DATA_W(DATA_W),
            .FULL_SCALE(FULL_SCALE), .ADDR_W(ADDR_W)) u_rom (
    .addr(addr_q), .data(carrier));

  assign period_stb = stb_q;

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    addr_q <= LAST); // R2
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (step && addr_q != LAST) |=> (addr_q == $past(addr_q) + 1'b1)); // R2
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    period_stb |=> !period_stb); // R5
  AST_STB_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    period_stb |-> (addr_q == '0 && carrier == '0)); // R5
  AST_NO_IDLE_MOVE: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(addr_q)); // R4
endmodule

// File: tb/sim_tri_carrier_gen.sv
module sim_tri_carrier_gen;
  localparam int STEPS = 98, PEAK = 48, FULL = 4800, BDIV = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ratio_sel = 2'd2;
  logic [15:0] carrier;
  logic        period_stb;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  tri_carrier_gen u0 (.clk(clk), .rst(rst), .ratio_sel(ratio_sel),
                      .carrier(carrier), .period_stb(period_stb));

  function automatic int exp_tri(int i);
    if (i <= PEAK) return (FULL * i) / PEAK;
    return (FULL * (STEPS - i)) / (STEPS - PEAK);
  endfunction

  // Behavioural reference model
  int m_addr = 0, m_phase = 0, m_code = 0;
  bit m_stb = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_addr = 0; m_phase = 0; m_code = 0; m_stb = 0;
    end else begin
      m_stb = 0;
      if (m_phase == (BDIV >> m_code) - 1) begin
        m_phase = 0;
        if (m_addr == STEPS - 1) begin
          m_addr = 0; m_code = int'(ratio_sel); m_stb = 1;
        end else m_addr++;
      end else m_phase++;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int cyc = 0, last_stb = 0, changes = 0, cur_code = 0, peak_seen = 0, nstb = 0;
    logic [15:0] prev;
    repeat (3) @(negedge clk);
    check(carrier == 0, "R1 carrier in reset", carrier, 0);
    check(period_stb == 0, "R1 strobe in reset", period_stb, 0);
    rst = 1'b0;
    @(negedge clk); cyc = 1;
    check(carrier == 0 && period_stb == 0, "R1 after release", carrier, 0);
    prev = carrier;
    while (cyc < 7000) begin
      @(negedge clk); cyc++;
      check(carrier == 16'(exp_tri(m_addr)), "R3 carrier word", carrier, exp_tri(m_addr));
      check(period_stb == m_stb, "R5 strobe", period_stb, m_stb);
      if (carrier != prev) changes++;
      prev = carrier;
      if (int'(carrier) > peak_seen) peak_seen = carrier;
      if (period_stb) begin
        nstb++;
        check(carrier == 0, "R5 strobe at sample 0", carrier, 0);
        check(cyc - last_stb == STEPS * (BDIV >> cur_code), "R4 R6 R7 period length",
              cyc - last_stb, STEPS * (BDIV >> cur_code));
        check(changes == STEPS, "R2 samples per period", changes, STEPS);
        check(peak_seen == FULL, "R3 peak value", peak_seen, FULL);
        cur_code = int'(ratio_sel);
        last_stb = cyc; changes = 0; peak_seen = 0;
      end
      // change the requested code in mid-period; effect is deferred to the wrap
      if (cyc % 333 == 0) ratio_sel = ratio_sel + 2'd1;
    end
    check(nstb >= 10, "R5 strobe count", nstb, 10);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule